// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches the command bus of a four-bank synchronous DRAM and never drives it. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines together with the bank-select bits and the auto/all-precharge address bit. From that it keeps a private picture of each bank: open, closing (precharge in progress) or idle. It also keeps a set of cycle counters per bank plus one counter shared by all banks.

A command that breaks a state rule or comes too soon after an earlier command produces a one-clock pulse on the violation outputs, together with a code that names the rule. The bank picture is then updated as if the command had been legal, so that later checks follow what the memory would actually do.

Timing values are given as parameters in nanoseconds, together with the clock period. They are turned into whole clock counts by rounding up. The write-to-precharge gap is given directly in clocks. Clock enable is taken to be permanently high. Data, read latency and low-power modes are not examined.

Top module: `sdmon_top`

## Requirements
- R1: A command is decoded from (cs_n, ras_n, cas_n, we_n) as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register load, 0110 burst stop, 0111 no-operation. Any cycle with cs_n=1 is ignored. No-operation, burst stop and ignored cycles never raise a violation. A command sampled at edge k is reported on viol_valid_o/viol_code_o after edge k+1, for exactly one cycle; otherwise viol_valid_o=0 and viol_code_o=0.
- R2: While rst_n is low, viol_valid_o=0 and viol_code_o=0, and all banks are idle once reset is released.
- R3: A read or write to a bank that is not open (idle or closing) gives code 1.
- R4: A read or write to an open bank fewer than ceil(T_RCD_NS/CLK_NS) cycles after that bank's activate gives code 2.
- R5: An activate to a bank that is already open gives code 3.
- R6: An activate fewer than ceil(T_RC_NS/CLK_NS) cycles after the previous activate of the same bank gives code 4.
- R7: An activate to a bank that is closing, meaning fewer than ceil(T_RP_NS/CLK_NS) cycles since its precharge, gives code 5.
- R8: An activate to a bank other than the one most recently activated, fewer than ceil(T_RRD_NS/CLK_NS) cycles after that activate, gives code 6.
- R9: A precharge reaches every bank when the all-bank bit a10=1, and only bank ba when a10=0. A targeted open bank whose activate is fewer than ceil(T_RAS_NS/CLK_NS) cycles old gives code 7. A targeted bank that is idle or closing is unaffected and raises nothing.
- R10: A precharge reaching an open bank fewer than T_DPL_CK cycles after a write to that bank gives code 8. The write command cycle is taken as the last data beat.
- R11: A refresh or mode-register load while any bank is open or closing gives code 9.
- R12: When several rules fail in one command, the reported code follows this priority: for an activate 3, then 4, then 5, then 6; for a read or write 1, then 2; for a precharge 7, then 8. Bank state is updated as if the command were legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| a10 | input | 1 | All-bank precharge select |
| viol_valid_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Rule code, 0 when no violation |

## Verification
Two checks can trip on the same command, and then the priority rule alone decides what is reported. An activate issued right after a precharge of a recently opened bank fails both the same-bank activate spacing and the closing-bank rule. A precharge one cycle after a write inside the open-time window fails both the open-time and the write-recovery rules. The stimulus builds both situations deliberately, and a behavioural model scores every rule on the command. The model expects the highest-priority code, and a coverage check confirms that such double hits occurred and matched.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

   typedef enum logic [2:0] {
      C_NONE = 3'd0,
      C_ACT  = 3'd1,
      C_RD   = 3'd2,
      C_WR   = 3'd3,
      C_PRE  = 3'd4,
      C_REF  = 3'd5,
      C_MRS  = 3'd6,
      C_BST  = 3'd7
   } cmd_e;

   typedef enum logic [3:0] {
      V_NONE      = 4'd0,
      V_RW_CLOSED = 4'd1,
      V_RCD       = 4'd2,
      V_ACT_OPEN  = 4'd3,
      V_RC        = 4'd4,
      V_RP        = 4'd5,
      V_RRD       = 4'd6,
      V_RAS       = 4'd7,
      V_DPL       = 4'd8,
      V_BUSY      = 4'd9
   } viol_e;

   // whole clocks covering a time in ns, rounded up
   function automatic int unsigned ns2clk(input int unsigned ns, input int unsigned tck);
      return (ns + tck - 1) / tck;
   endfunction

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
   import sdmon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);

   always_comb begin
      cmd_o = C_NONE;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = C_ACT;
            3'b101:  cmd_o = C_RD;
            3'b100:  cmd_o = C_WR;
            3'b010:  cmd_o = C_PRE;
            3'b001:  cmd_o = C_REF;
            3'b000:  cmd_o = C_MRS;
            3'b110:  cmd_o = C_BST;
            default: cmd_o = C_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sdmon_dncnt.sv
// Busy for SPAN-1 cycles after a load; a span of one or less is never busy.
module sdmon_dncnt #(
   parameter int unsigned SPAN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic clr_i,
   output logic busy_o
);

   localparam int unsigned LOADV = (SPAN > 1) ? SPAN - 1 : 0;
   localparam int unsigned W     = (LOADV > 1) ? $clog2(LOADV + 1) : 1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= W'(LOADV);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank #(
   parameter int unsigned RCD_C = 1,
   parameter int unsigned RAS_C = 1,
   parameter int unsigned RP_C  = 1,
   parameter int unsigned RC_C  = 1,
   parameter int unsigned DPL_C = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic pre_i,
   input  logic wr_i,
   output logic open_o,
   output logic prech_o,
   output logic rcd_busy_o,
   output logic ras_busy_o,
   output logic rc_busy_o,
   output logic dpl_busy_o
);

   logic open_q;
   logic close_now;

   assign close_now = pre_i && open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (act_i)
         open_q <= 1'b1;
      else if (close_now)
         open_q <= 1'b0;
   end

   assign open_o = open_q;

   sdmon_dncnt #(.SPAN(RCD_C)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load_i(act_i), .clr_i(1'b0), .busy_o(rcd_busy_o));

   sdmon_dncnt #(.SPAN(RAS_C)) u_ras (
      .clk(clk), .rst_n(rst_n), .load_i(act_i), .clr_i(1'b0), .busy_o(ras_busy_o));

   sdmon_dncnt #(.SPAN(RC_C)) u_rc (
      .clk(clk), .rst_n(rst_n), .load_i(act_i), .clr_i(1'b0), .busy_o(rc_busy_o));

   sdmon_dncnt #(.SPAN(RP_C)) u_rp (
      .clk(clk), .rst_n(rst_n), .load_i(close_now), .clr_i(act_i), .busy_o(prech_o));

   sdmon_dncnt #(.SPAN(DPL_C)) u_dpl (
      .clk(clk), .rst_n(rst_n), .load_i(wr_i), .clr_i(1'b0), .busy_o(dpl_busy_o));

endmodule

// File: rtl/sdmon_judge.sv
module sdmon_judge
   import sdmon_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   localparam int unsigned NB    = 1 << BANK_W
) (
   input  cmd_e              cmd_i,
   input  logic [BANK_W-1:0] ba_i,
   input  logic              a10_i,
   input  logic [NB-1:0]     open_v,
   input  logic [NB-1:0]     prech_v,
   input  logic [NB-1:0]     rcd_v,
   input  logic [NB-1:0]     ras_v,
   input  logic [NB-1:0]     rc_v,
   input  logic [NB-1:0]     dpl_v,
   input  logic              rrd_busy_i,
   input  logic [BANK_W-1:0] last_ba_i,
   output viol_e             code_o
);

   logic [NB-1:0] tgt;

   for (genvar i = 0; i < NB; i++) begin : g_tgt
      assign tgt[i] = a10_i || (ba_i == BANK_W'(i));
   end

   always_comb begin
      code_o = V_NONE;
      unique case (cmd_i)
         C_ACT: begin
            if (open_v[ba_i])                          code_o = V_ACT_OPEN;
            else if (rc_v[ba_i])                       code_o = V_RC;
            else if (prech_v[ba_i])                    code_o = V_RP;
            else if (rrd_busy_i && ba_i != last_ba_i)  code_o = V_RRD;
         end
         C_RD, C_WR: begin
            if (!open_v[ba_i])                         code_o = V_RW_CLOSED;
            else if (rcd_v[ba_i])                      code_o = V_RCD;
         end
         C_PRE: begin
            if (|(tgt & open_v & ras_v))               code_o = V_RAS;
            else if (|(tgt & open_v & dpl_v))          code_o = V_DPL;
         end
         C_REF, C_MRS: begin
            if ((|open_v) || (|prech_v))               code_o = V_BUSY;
         end
         default: code_o = V_NONE;
      endcase
   end

endmodule

// File: rtl/sdmon_top.sv
module sdmon_top
   import sdmon_pkg::*;
#(
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned CLK_NS    = 4,
   parameter int unsigned T_RCD_NS  = 20,
   parameter int unsigned T_RAS_NS  = 45,
   parameter int unsigned T_RP_NS   = 20,
   parameter int unsigned T_RC_NS   = 67,
   parameter int unsigned T_RRD_NS  = 15,
   parameter int unsigned T_DPL_CK  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] ba,
   input  logic              a10,
   output logic              viol_valid_o,
   output logic [3:0]        viol_code_o
);

   localparam int unsigned NB    = 1 << BANK_W;
   localparam int unsigned RCD_C = ns2clk(T_RCD_NS, CLK_NS);
   localparam int unsigned RAS_C = ns2clk(T_RAS_NS, CLK_NS);
   localparam int unsigned RP_C  = ns2clk(T_RP_NS, CLK_NS);
   localparam int unsigned RC_C  = ns2clk(T_RC_NS, CLK_NS);
   localparam int unsigned RRD_C = ns2clk(T_RRD_NS, CLK_NS);

   if (CLK_NS == 0) begin : g_bad_clk
      $error("sdmon_top: CLK_NS must be nonzero");
   end
   if (BANK_W < 1 || BANK_W > 3) begin : g_bad_bank
      $error("sdmon_top: BANK_W must be 1 to 3");
   end

   cmd_e cmd;

   sdmon_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd));

   logic [NB-1:0] open_v, prech_v, rcd_v, ras_v, rc_v, dpl_v;

   for (genvar i = 0; i < NB; i++) begin : g_bank
      logic sel;
      assign sel = (ba == BANK_W'(i));
      sdmon_bank #(
         .RCD_C(RCD_C), .RAS_C(RAS_C), .RP_C(RP_C), .RC_C(RC_C), .DPL_C(T_DPL_CK)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .act_i      (cmd == C_ACT && sel),
         .pre_i      (cmd == C_PRE && (a10 || sel)),
         .wr_i       (cmd == C_WR && sel),
         .open_o     (open_v[i]),
         .prech_o    (prech_v[i]),
         .rcd_busy_o (rcd_v[i]),
         .ras_busy_o (ras_v[i]),
         .rc_busy_o  (rc_v[i]),
         .dpl_busy_o (dpl_v[i])
      );
   end

   logic              rrd_busy;
   logic [BANK_W-1:0] last_ba_q;

   sdmon_dncnt #(.SPAN(RRD_C)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load_i(cmd == C_ACT), .clr_i(1'b0), .busy_o(rrd_busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_ba_q <= '0;
      else if (cmd == C_ACT)
         last_ba_q <= ba;
   end

   viol_e code;

   sdmon_judge #(.BANK_W(BANK_W)) u_judge (
      .cmd_i      (cmd),
      .ba_i       (ba),
      .a10_i      (a10),
      .open_v     (open_v),
      .prech_v    (prech_v),
      .rcd_v      (rcd_v),
      .ras_v      (ras_v),
      .rc_v       (rc_v),
      .dpl_v      (dpl_v),
      .rrd_busy_i (rrd_busy),
      .last_ba_i  (last_ba_q),
      .code_o     (code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_valid_o <= 1'b0;
         viol_code_o  <= 4'd0;
      end else begin
         viol_valid_o <= (code != V_NONE);
         viol_code_o  <= code;
      end
   end

endmodule

// File: rtl/sdmon_chk.sv
module sdmon_chk
   import sdmon_pkg::*;
#(
   parameter int unsigned BANK_W   = 2,
   parameter int unsigned CLK_NS   = 4,
   parameter int unsigned T_RCD_NS = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input logic              viol_valid_o,
   input logic [3:0]        viol_code_o
);

   localparam int unsigned RCD_C = ns2clk(T_RCD_NS, CLK_NS);

   logic [1:0] up_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         up_q <= 2'd0;
      else if (up_q != 2'd3)
         up_q <= up_q + 2'd1;
   end

   logic is_act, is_rw, is_quiet, is_busycmd;
   assign is_act     = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign is_rw      = !cs_n &&  ras_n && !cas_n;
   assign is_quiet   =  cs_n || (ras_n && cas_n);
   assign is_busycmd = !cs_n && !ras_n && !cas_n;

   // R2
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !viol_valid_o)
      else $error("reset_quiet_chk");

   // R1
   quiet_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q >= 2'd1) && $past(is_quiet) |-> !viol_valid_o)
      else $error("quiet_cmd_chk");

   // R4
   rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q >= 2'd2) && (RCD_C > 1) && $past(is_act, 2) && $past(is_rw) &&
      ($past(ba, 2) == $past(ba)) |-> viol_valid_o && viol_code_o == 4'd2)
      else $error("rcd_gap_chk");

   // R11
   busy_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q >= 2'd2) && $past(is_act, 2) && $past(is_busycmd) |->
      viol_valid_o && viol_code_o == 4'd9)
      else $error("busy_ref_chk");

endmodule

bind sdmon_top sdmon_chk #(
   .BANK_W(BANK_W), .CLK_NS(CLK_NS), .T_RCD_NS(T_RCD_NS)
) u_chk (.*);

// File: tb/sdmon_top_test.sv
`timescale 1ns/1ps
module sdmon_top_test;

   localparam int TCK = 4;
   localparam int RCD = (20 + TCK - 1) / TCK;
   localparam int RAS = (45 + TCK - 1) / TCK;
   localparam int RP  = (20 + TCK - 1) / TCK;
   localparam int RC  = (67 + TCK - 1) / TCK;
   localparam int RRD = (15 + TCK - 1) / TCK;
   localparam int DPL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [1:0] ba = 2'd0;
   logic viol_valid_o;
   logic [3:0] viol_code_o;

   always #2 clk = ~clk;

   sdmon_top uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10),
      .viol_valid_o(viol_valid_o), .viol_code_o(viol_code_o));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int cyc = 0;
   int la[4], lp[4], lw[4];
   bit act_m[4];
   int laa = -1000;
   int lab = 0;
   int exp_code = 0;
   bit exp_multi = 0;
   int seen[10];
   int multi_ok = 0;

   initial begin
      for (int i = 0; i < 4; i++) begin
         la[i] = -1000; lp[i] = -1000; lw[i] = -1000; act_m[i] = 0;
      end
      for (int i = 0; i < 10; i++) seen[i] = 0;
   end

   function automatic string tag_of(input int c);
      case (c)
         1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5: return "R7";  6: return "R8";
         7: return "R9";  8: return "R10"; 9: return "R11";
         default: return "R1";
      endcase
   endfunction

   always @(posedge clk) begin
      int c, hits;
      bit closing, ras_hit, dpl_hit, any_busy;
      c = 0; hits = 0;
      if (!rst_n) begin
         exp_code  <= 0;
         exp_multi <= 0;
      end else begin
         if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
               3'b011: begin
                  closing = !act_m[ba] && (cyc - lp[ba] < RP);
                  if (act_m[ba]) hits++;
                  if (cyc - la[ba] < RC) hits++;
                  if (closing) hits++;
                  if (lab != int'(ba) && cyc - laa < RRD) hits++;
                  if (act_m[ba]) c = 3;
                  else if (cyc - la[ba] < RC) c = 4;
                  else if (closing) c = 5;
                  else if (lab != int'(ba) && cyc - laa < RRD) c = 6;
                  act_m[ba] = 1; la[ba] = cyc; lp[ba] = -1000;
                  laa = cyc; lab = int'(ba);
               end
               3'b101, 3'b100: begin
                  if (!act_m[ba]) begin c = 1; hits = 1; end
                  else if (cyc - la[ba] < RCD) begin c = 2; hits = 1; end
                  if (!we_n == 1'b1) lw[ba] = cyc;
               end
               3'b010: begin
                  ras_hit = 0; dpl_hit = 0;
                  for (int i = 0; i < 4; i++)
                     if ((a10 || int'(ba) == i) && act_m[i]) begin
                        if (cyc - la[i] < RAS) ras_hit = 1;
                        if (cyc - lw[i] < DPL) dpl_hit = 1;
                     end
                  hits = int'(ras_hit) + int'(dpl_hit);
                  if (ras_hit) c = 7; else if (dpl_hit) c = 8;
                  for (int i = 0; i < 4; i++)
                     if ((a10 || int'(ba) == i) && act_m[i]) begin
                        act_m[i] = 0; lp[i] = cyc;
                     end
               end
               3'b001, 3'b000: begin
                  any_busy = 0;
                  for (int i = 0; i < 4; i++)
                     if (act_m[i] || cyc - lp[i] < RP) any_busy = 1;
                  if (any_busy) begin c = 9; hits = 1; end
               end
               default: ;
            endcase
         end
         exp_code  <= c;
         exp_multi <= (hits > 1);
         cyc = cyc + 1;
      end
   end

   always @(negedge clk) begin
      string t;
      checks++;
      if (!rst_n) t = "R2";
      else if (exp_multi) t = "R12";
      else if (exp_code != 0) t = tag_of(exp_code);
      else t = tag_of(int'(viol_code_o));
      if (viol_valid_o !== (exp_code != 0) || int'(viol_code_o) !== exp_code) begin
         errors++;
         $display("FAIL %s cyc %0d: valid=%0b code=%0d expected valid=%0b code=%0d",
                  t, cyc, viol_valid_o, viol_code_o, (exp_code != 0), exp_code);
      end else if (rst_n && exp_code != 0) begin
         seen[exp_code]++;
         if (exp_multi) multi_ok++;
      end
   end

   task automatic put(input logic c, r, ca, w, input logic [1:0] b, input logic a);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
   endtask

   task automatic act(input logic [1:0] b);  put(0, 0, 1, 1, b, 0); endtask
   task automatic rd(input logic [1:0] b);   put(0, 1, 0, 1, b, 0); endtask
   task automatic wr(input logic [1:0] b);   put(0, 1, 0, 0, b, 0); endtask
   task automatic pre(input logic [1:0] b, input logic a); put(0, 0, 1, 0, b, a); endtask
   task automatic refr();                    put(0, 0, 0, 1, 2'd0, 0); endtask
   task automatic mrs();                     put(0, 0, 0, 0, 2'd0, 0); endtask
   task automatic nop(input int n);
      for (int i = 0; i < n; i++) put(0, 1, 1, 1, 2'd0, 0);
   endtask

   task automatic cover_chk(input int code, input string t);
      checks++;
      if (seen[code] == 0) begin
         errors++;
         $display("FAIL %s code %0d observed %0d times, expected at least 1", t, code, seen[code]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: deselected cycle with a mode-load pattern, and a burst stop
      put(1, 0, 0, 0, 2'd1, 1);
      put(0, 1, 1, 0, 2'd0, 0);
      nop(2);
      rd(2'd0);                 // R3
      act(2'd0); rd(2'd0);      // R4
      nop(6);
      wr(2'd0); pre(2'd0, 0);   // R9 + R10 together, R12
      refr();                   // R11 while closing
      act(2'd0);                // R6 + R7 together, R12
      nop(20);
      act(2'd1); act(2'd2);     // R8
      act(2'd1);                // R5 with R6
      nop(20);
      wr(2'd1); pre(2'd1, 0);   // R10 alone
      nop(3);
      pre(2'd0, 1);             // legal all-bank close
      nop(10);
      refr(); mrs();            // legal with all idle
      act(2'd3); nop(20);
      pre(2'd3, 0); nop(1);
      act(2'd3);                // R7 alone
      nop(10);
      pre(2'd0, 1); nop(10);
      act(2'd0); nop(3);
      act(2'd1);                // spacing exactly met
      pre(2'd2, 0);             // idle bank, no effect
      pre(2'd0, 1);             // R9 through all-bank path
      rd(2'd0);                 // R3 after close
      nop(5);
      cover_chk(1, "R3"); cover_chk(2, "R4"); cover_chk(3, "R5");
      cover_chk(4, "R6"); cover_chk(5, "R7"); cover_chk(6, "R8");
      cover_chk(7, "R9"); cover_chk(8, "R10"); cover_chk(9, "R11");
      checks++;
      if (multi_ok < 2) begin
         errors++;
         $display("FAIL R12 matched multi-rule cases %0d, expected at least 2", multi_ok);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule